// File: doc/BRIEF.md
# Multicart PRG Address Composer

This block forms the upper cartridge program-ROM address bits, A24 down to A13, for a multi-game cartridge. An inner bank controller supplies an 8 KiB bank number for the CPU window being accessed. A set of outer registers adds a large offset above it and can take over parts of the address. The block merges the two.

There are two banking modes. In inner-controller mode the inner bank drives the low address bits and the outer offset is placed in 128 KiB units. In discrete mode register fields pick a fixed 32 KiB or 16 KiB bank. In both modes, four per-bit select bits decide whether A17, A18, A19 and A20 come from the offset or from the inner controller. The select bits do not all use the same polarity.

A separate override, called quirk mode here, redirects the two top CPU windows to inner bank 0 when the inner controller uses its normal program layout. The output is purely combinational from the register contents, the inner bank and the CPU address.

Top module: `mc_prg_compose`

## Requirements
- R1: Output bits A24..A21 (prgHi[11:8]) always equal {reg0[5], reg0[4], reg1[3], reg1[2]}.
- R2: A17 (prgHi[4]) equals reg0[0] when reg0[6]=1, and the effective inner bank bit A17 when reg0[6]=0.
- R3: A18 (prgHi[5]) equals reg0[1] when reg1[6]=1, and the effective inner bit A18 when reg1[6]=0.
- R4: A19 (prgHi[6]) equals the inner bit A19 when reg1[5]=1, and reg0[2] when reg1[5]=0.
- R5: A20 (prgHi[7]) equals the inner bit A20 when reg1[7]=1, and reg1[4] when reg1[7]=0.
- R6: In inner-controller mode (reg3[4]=0), A16..A13 (prgHi[3:0]) equal the effective inner bank bits 3..0.
- R7: In discrete mode (reg3[4]=1), A16..A15 equal reg3[3:2] and A13 equals CPU A13.
- R8: In discrete mode with reg1[0]=1 (32 KiB banks), A14 equals CPU A14.
- R9: In discrete mode with reg1[0]=0 (16 KiB banks), A14 equals reg3[1] whatever CPU A14 is.
- R10: When reg3[6]=1, innerPrgMode=0 and CPU A14=1 (windows 0xC000 and 0xE000), the effective inner bank is 0. Otherwise it is innerBank, whose bit i stands for address bit A(13+i).
- R11: When innerPrgMode=1, reg3[6] has no effect on the output.
- R12: The output reflects a change of any input in the same cycle, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg0 | input | 8 | Outer register 0: offset bits and the A17 select |
| reg1 | input | 8 | Outer register 1: offset bits, the A18/A19/A20 selects and the 32K/16K size |
| reg3 | input | 8 | Outer register 3: discrete bank, mode bit and quirk bit |
| innerBank | input | 8 | Inner controller 8 KiB bank for the current window, A20..A13 |
| innerPrgMode | input | 1 | Inner controller program layout: 0 normal, 1 inverted |
| cpuA14 | input | 1 | CPU address bit 14 |
| cpuA13 | input | 1 | CPU address bit 13 |
| prgHi | output | 12 | Cartridge program address A24..A13 |

## Verification
The embedded assertions check on every evaluation that the top offset bits follow the registers, that the A17 select is honoured, that discrete mode drives A16, A15 and A13 from its fields and the CPU, and that the quirk override zeroes the inner low bits. Whether the remaining select polarities are right, whether the inverted layout really hides the quirk bit, and whether the output reacts in the same cycle are shown by the bench's directed scenarios and by its comparison of a behavioural model against the output over a pseudo-random sweep.

// File: rtl/mc_prg_pkg.sv
package mc_prg_pkg;
  localparam int REG_W    = 8;
  localparam int INNER_W  = 8;                  // inner bank bits A20..A13
  localparam int MASK_N   = 4;                  // selectable bits A17..A20
  localparam int LOW_N    = INNER_W - MASK_N;   // A16..A13
  localparam int OFF_W    = 8;                  // offset bits A24..A17
  localparam int TOP_N    = OFF_W - MASK_N;     // A24..A21
  localparam int OUT_W    = LOW_N + OFF_W;      // A24..A13
  localparam int DISC_W   = 3;                  // discrete A16..A14

  // 1 = raw select bit means "inner controller" (inverted sense)
  localparam logic [MASK_N-1:0] SEL_INV = 4'b1100;

  typedef struct packed {
    logic [MASK_N-1:0] useOffset;
    logic              discrete;
    logic              a14FromCpu;
    logic              zeroInner;
  } prgCtrl_t;

  typedef struct packed {
    logic [OFF_W-1:0]  outerOff;
    logic [DISC_W-1:0] discBank;
  } prgFields_t;
endpackage

// File: rtl/mc_prg_ctrl.sv
module mc_prg_ctrl
  import mc_prg_pkg::*;
(
  input  logic [REG_W-1:0] reg0,
  input  logic [REG_W-1:0] reg1,
  input  logic [REG_W-1:0] reg3,
  input  logic             innerPrgMode,
  input  logic             cpuA14,
  output prgCtrl_t         ctrl,
  output prgFields_t       fields
);
  logic [MASK_N-1:0] rawSel;
  logic [MASK_N-1:0] useOff;

  // raw select bits ordered A20, A19, A18, A17
  assign rawSel = {reg1[7], reg1[5], reg1[6], reg0[6]};

  for (genvar i = 0; i < MASK_N; i++) begin : g_sel
    if (SEL_INV[i]) begin : g_inv
      assign useOff[i] = ~rawSel[i];
    end else begin : g_dir
      assign useOff[i] = rawSel[i];
    end
  end

  always_comb begin
    ctrl.useOffset  = useOff;
    ctrl.discrete   = reg3[4];
    ctrl.a14FromCpu = reg1[0];
    ctrl.zeroInner  = reg3[6] & ~innerPrgMode & cpuA14;
    fields.outerOff = {reg0[5], reg0[4], reg1[3], reg1[2],
                       reg1[4], reg0[2], reg0[1], reg0[0]};
    fields.discBank = reg3[3:1];
  end

  // R11: inverted layout never raises the override strobe
  always_comb begin
    if (innerPrgMode)
      p_inverted_no_quirk_r11: assert (!ctrl.zeroInner)
        else $error("quirk strobe active in inverted layout");
  end
endmodule

// File: rtl/mc_prg_path.sv
module mc_prg_path
  import mc_prg_pkg::*;
(
  input  prgCtrl_t           ctrl,
  input  prgFields_t         fields,
  input  logic [INNER_W-1:0] innerBank,
  input  logic               cpuA14,
  input  logic               cpuA13,
  output logic [OUT_W-1:0]   prgHi
);
  logic [INNER_W-1:0] innerEff;
  logic [LOW_N-1:0]   lowDisc;
  logic [LOW_N-1:0]   lowBits;
  logic [MASK_N-1:0]  midBits;

  assign innerEff = ctrl.zeroInner ? '0 : innerBank;

  always_comb begin
    lowDisc = {fields.discBank[DISC_W-1:1],
               ctrl.a14FromCpu ? cpuA14 : fields.discBank[0],
               cpuA13};
    lowBits = ctrl.discrete ? lowDisc : innerEff[LOW_N-1:0];
  end

  for (genvar i = 0; i < MASK_N; i++) begin : g_mid
    assign midBits[i] = ctrl.useOffset[i] ? fields.outerOff[i]
                                          : innerEff[LOW_N+i];
  end

  assign prgHi = {fields.outerOff[OFF_W-1:MASK_N], midBits, lowBits};

  // R10: override with inner mode leaves low bits at zero
  always_comb begin
    if (ctrl.zeroInner && !ctrl.discrete)
      p_quirk_zero_r10: assert (prgHi[LOW_N-1:0] == '0)
        else $error("override did not zero low bits");
  end
endmodule

// File: rtl/mc_prg_compose.sv
module mc_prg_compose
  import mc_prg_pkg::*;
(
  input  logic [7:0]  reg0,
  input  logic [7:0]  reg1,
  input  logic [7:0]  reg3,
  input  logic [7:0]  innerBank,
  input  logic        innerPrgMode,
  input  logic        cpuA14,
  input  logic        cpuA13,
  output logic [11:0] prgHi
);
  prgCtrl_t   ctrl;
  prgFields_t fields;

  mc_prg_ctrl u_ctrl (
    .reg0(reg0), .reg1(reg1), .reg3(reg3),
    .innerPrgMode(innerPrgMode), .cpuA14(cpuA14),
    .ctrl(ctrl), .fields(fields)
  );

  mc_prg_path u_path (
    .ctrl(ctrl), .fields(fields), .innerBank(innerBank),
    .cpuA14(cpuA14), .cpuA13(cpuA13), .prgHi(prgHi)
  );

  logic quirkHit;
  assign quirkHit = reg3[6] & ~innerPrgMode & cpuA14;

  always_comb begin
    p_outer_top_r1: assert (prgHi[11:8] == {reg0[5], reg0[4], reg1[3], reg1[2]})
      else $error("top offset bits wrong");
    if (reg0[6])
      p_a17_offset_r2: assert (prgHi[4] == reg0[0])
        else $error("A17 not from offset");
    if (!reg0[6] && !quirkHit)
      p_a17_inner_r2: assert (prgHi[4] == innerBank[4])
        else $error("A17 not from inner bank");
    if (reg3[4])
      p_disc_low_r7: assert (prgHi[3:2] == reg3[3:2] && prgHi[0] == cpuA13)
        else $error("discrete low bits wrong");
    if (reg3[4] && !reg1[0])
      p_disc16_r9: assert (prgHi[1] == reg3[1])
        else $error("16K A14 wrong");
  end
endmodule

// File: tb/tb_mc_prg_compose.sv
module tb_mc_prg_compose;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst = 1;
  logic [7:0] reg0 = 0, reg1 = 0, reg3 = 0, innerBank = 0;
  logic innerPrgMode = 0, cpuA14 = 0, cpuA13 = 0;
  logic [11:0] prgHi;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_prg_compose dut (
    .reg0(reg0), .reg1(reg1), .reg3(reg3), .innerBank(innerBank),
    .innerPrgMode(innerPrgMode), .cpuA14(cpuA14), .cpuA13(cpuA13),
    .prgHi(prgHi)
  );

  function automatic logic [11:0] model();
    int addr;   // byte address bits as integer, in units of 8 KiB
    int bank;
    int off;
    bank = (reg3[6] && !innerPrgMode && cpuA14) ? 0 : int'(innerBank);
    off  = 0;
    off += reg0[5] * 128 + reg0[4] * 64 + reg1[3] * 32 + reg1[2] * 16;
    off += reg1[4] * 8 + reg0[2] * 4 + reg0[1] * 2 + reg0[0];
    addr = (off / 16) * 256;
    addr += (reg0[6] ? (off % 2) : ((bank / 16) % 2)) * 16;
    addr += (reg1[6] ? ((off / 2) % 2) : ((bank / 32) % 2)) * 32;
    addr += (reg1[5] ? ((bank / 64) % 2) : ((off / 4) % 2)) * 64;
    addr += (reg1[7] ? ((bank / 128) % 2) : ((off / 8) % 2)) * 128;
    if (reg3[4]) begin
      addr += int'(reg3[3:2]) * 4;
      addr += (reg1[0] ? int'(cpuA14) : int'(reg3[1])) * 2;
      addr += int'(cpuA13);
    end else begin
      addr += bank % 16;
    end
    return addr[11:0];
  endfunction

  task automatic check(string tag);
    logic [11:0] exp;
    exp = model();
    nChecks++;
    if (prgHi !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, prgHi, exp);
    end
  endtask

  task automatic apply(logic [7:0] r0, logic [7:0] r1, logic [7:0] r3,
                       logic [7:0] ib, logic pm, logic a14, logic a13,
                       string tag);
    @(posedge clk);
    #1;
    reg0 = r0; reg1 = r1; reg3 = r3; innerBank = ib;
    innerPrgMode = pm; cpuA14 = a14; cpuA13 = a13;
    @(negedge clk);
    check(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // cleared registers: inner bank passes through, offset zero
    check("R6 reset state");
    if (prgHi !== 12'h000) begin
      nFails++; $display("FAIL R6 reset: got %h expected 000", prgHi);
    end
    nChecks++;

    apply(8'h30, 8'h0C, 8'h00, 8'h0F, 0, 0, 0, "R1 top offset ones");
    if (prgHi[11:8] !== 4'hF) begin nFails++; $display("FAIL R1: got %h expected f", prgHi[11:8]); end
    nChecks++;
    apply(8'h41, 8'h00, 8'h00, 8'h00, 0, 0, 0, "R2 A17 from offset");
    apply(8'h00, 8'h00, 8'h00, 8'h10, 0, 0, 0, "R2 A17 from inner");
    apply(8'h02, 8'h40, 8'h00, 8'h20, 0, 0, 0, "R3 A18 from offset");
    apply(8'h00, 8'h20, 8'h00, 8'h40, 0, 0, 0, "R4 A19 from inner");
    apply(8'h04, 8'h00, 8'h00, 8'h40, 0, 0, 0, "R4 A19 from offset");
    apply(8'h00, 8'h80, 8'h00, 8'h80, 0, 0, 0, "R5 A20 from inner");
    apply(8'h00, 8'h10, 8'h00, 8'h80, 0, 0, 0, "R5 A20 from offset");
    apply(8'h00, 8'hA0, 8'h00, 8'hA5, 0, 1, 1, "R6 inner low bits");
    apply(8'h00, 8'h00, 8'h1C, 8'hFF, 0, 0, 1, "R7 discrete low");
    apply(8'h00, 8'h01, 8'h10, 8'h00, 0, 1, 0, "R8 32K A14 high");
    apply(8'h00, 8'h01, 8'h12, 8'h00, 0, 0, 0, "R8 32K A14 low");
    apply(8'h00, 8'h00, 8'h12, 8'h00, 0, 0, 0, "R9 16K A14 field");
    apply(8'h00, 8'h00, 8'h10, 8'h00, 0, 1, 0, "R9 16K ignores cpu");
    apply(8'h00, 8'hA0, 8'h40, 8'hFF, 0, 1, 0, "R10 quirk zero");
    if (prgHi !== 12'h000) begin nFails++; $display("FAIL R10: got %h expected 000", prgHi); end
    nChecks++;
    apply(8'h00, 8'hA0, 8'h40, 8'hFF, 0, 0, 1, "R10 quirk low window");
    apply(8'h00, 8'hA0, 8'h50, 8'hF0, 0, 1, 0, "R10 quirk discrete");
    apply(8'h00, 8'hA0, 8'h40, 8'hFE, 1, 1, 1, "R11 inverted unaffected");
    if (prgHi !== 12'h0FE) begin nFails++; $display("FAIL R11: got %h expected 0fe", prgHi); end
    nChecks++;

    // R12: same-cycle response to a mid-cycle input change
    @(posedge clk); #1;
    reg3 = 8'h00; reg1 = 8'hA0; reg0 = 8'h00; innerPrgMode = 0;
    innerBank = 8'h11;
    #1;
    check("R12 immediate a");
    innerBank = 8'h22;
    #1;
    check("R12 immediate b");

    lfsr = 32'hACE1_2357;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] v;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      v = lfsr * 32'h9E37_79B9;
      apply(v[7:0], v[15:8], v[23:16], v[31:24], lfsr[3], lfsr[7], lfsr[11],
            "R12 sweep");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule